// File: doc/BRIEF.md
# ATM Virtual Path and Channel Lookup Matcher

This block is the lookup stage of an ATM cell switch. It holds a small table of 64-bit entries. Each entry carries a path identifier (VPI), a channel identifier (VCI) and a 32-bit result word. When a cell header arrives, the block compares the VPI/VCI key against every entry at once. An entry whose fields both equal the key is a channel hit. An entry whose VCI field is all ones and whose VPI equals the key is a path hit. The block reports whether it found an entry, whether that entry is path-level, and the entry's result word. Every lookup takes the same number of cycles.

The table is kept up to date with insert and delete commands that carry a full 64-bit entry. These commands follow switch-specific replacement rules. A channel insert takes over a path entry with the same VPI. A channel delete that finds no channel entry removes the path entry with the same VPI. A mode input narrows the VPI to its low 8 bits, for user-network interface traffic, and applies to both lookups and commands.

Top module: `atm_circuit_matcher`

## Requirements
- R1: Entries hold the result word in bits 31..0, the VCI in bits 47..32 and the VPI in bits 59..48. Keys hold the VCI in bits 15..0 and the VPI in bits 27..16. An entry whose VCI is not 0xFFFF hits when both fields equal the key. The result then has hit=1, path=0 and the word from entry bits 31..0.
- R2: An entry whose VCI field is 0xFFFF hits when its VPI equals the key VPI, whatever the key VCI is. The result then has hit=1, path=1 and that entry's word.
- R3: When a channel entry and a path entry both match one key, the channel entry is reported and path stays 0.
- R4: When no entry matches, hit=0, path=0 and the word is zero.
- R5: With the 12-bit VPI selected (narrow input 0), entry bits 63..60 and key bits 31..28 do not affect the compare.
- R6: With narrow input 1, only entry bits 55..48 are compared against key bits 23..16 as the VPI. Entry bits 63..56 and key bits 31..24 are ignored.
- R7: A lookup sampled at clock edge k produces result_valid=1 for one cycle after edge k+2, with the same latency for channel hits, path hits and misses. When result_valid is 0, hit, path and word are 0.
- R8: Inserting an entry whose VPI and VCI equal those of a stored entry replaces that entry, even when the table is full. No second copy is made, and the entry count never drops on an insert.
- R9: Inserting a channel entry (VCI not 0xFFFF) whose VPI equals that of a stored path entry overwrites that path entry. After this, other VCIs on that VPI miss.
- R10: Deleting an entry whose VPI and VCI equal those of a stored entry removes it. The entry count never rises on a delete.
- R11: Deleting a channel entry that is not stored, while a path entry with the same VPI is stored, removes the path entry. Channel entries on that VPI are kept.
- R12: An insert into a full table that has no replacement target is dropped, and a lookup of that entry misses.
- R13: Reset empties the table and clears all result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | Start a lookup with lookup_key |
| lookup_key | input | 32 | VCI in 15..0, VPI in 27..16 |
| vpi_narrow | input | 1 | 1 selects the 8-bit VPI for lookups and commands |
| cmd_valid | input | 1 | Apply an insert or delete this cycle |
| cmd_del | input | 1 | 0 insert, 1 delete |
| cmd_entry | input | 64 | Entry used by the command |
| result_valid | output | 1 | Lookup result present |
| result_hit | output | 1 | An entry matched |
| result_path | output | 1 | The match was a path entry |
| result_word | output | 32 | Bits 31..0 of the matched entry, else zero |

## Verification
A corrupted valid bit or stored field shows up at the ports on the next lookup of that key: the hit disappears or the wrong word comes out two cycles after the lookup is sampled. A replacement rule that picks the wrong slot leaves a stale path entry behind. That stale entry answers later lookups with path=1 where a channel hit, or a miss, is expected. Each command is therefore followed by lookups of both the affected channel and the affected path. A wrong latency or priority shows up in the same result cycle as the lookup that exposes it.

// File: rtl/atm_match_pkg.sv
package atm_match_pkg;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_CHAN = 2'd1,
      HIT_PATH = 2'd2
   } hit_kind_e;

   // channel matches take precedence over path matches
   function automatic hit_kind_e classify_hit(input logic any_chan, input logic any_path);
      if (any_chan)      return HIT_CHAN;
      else if (any_path) return HIT_PATH;
      else               return HIT_NONE;
   endfunction

endpackage

// File: rtl/atm_field_cmp.sv
module atm_field_cmp #(
   parameter int VCI_W        = 16,
   parameter int VPI_W        = 12,
   parameter int VPI_NARROW_W = 8
) (
   input  logic [VPI_W-1:0] entry_vpi,
   input  logic [VCI_W-1:0] entry_vci,
   input  logic [VPI_W-1:0] probe_vpi,
   input  logic [VCI_W-1:0] probe_vci,
   input  logic             narrow,
   output logic             vpi_eq,
   output logic             vci_eq,
   output logic             is_path
);

   localparam logic [VPI_W-1:0] WIDE_MASK   = {VPI_W{1'b1}};
   localparam logic [VPI_W-1:0] NARROW_MASK = {{(VPI_W-VPI_NARROW_W){1'b0}}, {VPI_NARROW_W{1'b1}}};

   logic [VPI_W-1:0] vpi_mask;

   assign vpi_mask = narrow ? NARROW_MASK : WIDE_MASK;
   assign vpi_eq   = ((entry_vpi ^ probe_vpi) & vpi_mask) == '0;
   assign vci_eq   = entry_vci == probe_vci;
   assign is_path  = &entry_vci;

endmodule

// File: rtl/atm_first_pick.sv
module atm_first_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   // isolate the lowest set request bit
   assign grant = req & (~req + ONE);
   assign any   = |req;

endmodule

// File: rtl/atm_entry_table.sv
module atm_entry_table #(
   parameter int DEPTH        = 8,
   parameter int ENTRY_W      = 64,
   parameter int OUT_W        = 32,
   parameter int VCI_W        = 16,
   parameter int VPI_W        = 12,
   parameter int VPI_NARROW_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cmd_valid,
   input  logic                           cmd_del,
   input  logic [ENTRY_W-1:0]             cmd_entry,
   input  logic                           narrow,
   output logic [DEPTH-1:0][ENTRY_W-1:0]  tbl_entries,
   output logic [DEPTH-1:0]               tbl_valid
);

   localparam int VCI_LSB = OUT_W;
   localparam int VPI_LSB = OUT_W + VCI_W;

   logic [DEPTH-1:0][ENTRY_W-1:0] entries_q;
   logic [DEPTH-1:0]              valid_q;

   logic [VPI_W-1:0] cmd_vpi;
   logic [VCI_W-1:0] cmd_vci;
   logic             cmd_is_path;

   logic [DEPTH-1:0] c_vpi_eq, c_vci_eq, c_is_path;
   logic [DEPTH-1:0] exact_req, pathtgt_req, free_req;
   logic [DEPTH-1:0] exact_gnt, pathtgt_gnt, free_gnt;
   logic             any_exact, any_pathtgt, any_free;
   logic [DEPTH-1:0] ins_tgt, del_tgt;

   assign cmd_vpi     = cmd_entry[VPI_LSB +: VPI_W];
   assign cmd_vci     = cmd_entry[VCI_LSB +: VCI_W];
   assign cmd_is_path = &cmd_vci;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmd_cmp
      atm_field_cmp #(
         .VCI_W       (VCI_W),
         .VPI_W       (VPI_W),
         .VPI_NARROW_W(VPI_NARROW_W)
      ) u_cmp (
         .entry_vpi (entries_q[g][VPI_LSB +: VPI_W]),
         .entry_vci (entries_q[g][VCI_LSB +: VCI_W]),
         .probe_vpi (cmd_vpi),
         .probe_vci (cmd_vci),
         .narrow    (narrow),
         .vpi_eq    (c_vpi_eq[g]),
         .vci_eq    (c_vci_eq[g]),
         .is_path   (c_is_path[g])
      );
      assign exact_req[g]   = valid_q[g] & c_vpi_eq[g] & c_vci_eq[g];
      assign pathtgt_req[g] = valid_q[g] & c_vpi_eq[g] & c_is_path[g] & ~cmd_is_path;
      assign free_req[g]    = ~valid_q[g];
   end

   atm_first_pick #(.N(DEPTH)) u_pick_exact (.req(exact_req),   .grant(exact_gnt),   .any(any_exact));
   atm_first_pick #(.N(DEPTH)) u_pick_path  (.req(pathtgt_req), .grant(pathtgt_gnt), .any(any_pathtgt));
   atm_first_pick #(.N(DEPTH)) u_pick_free  (.req(free_req),    .grant(free_gnt),    .any(any_free));

   // replacement order: identical key, then same-VPI path, then an empty slot
   always_comb begin
      if (any_exact)        ins_tgt = exact_gnt;
      else if (any_pathtgt) ins_tgt = pathtgt_gnt;
      else if (any_free)    ins_tgt = free_gnt;
      else                  ins_tgt = '0;
      del_tgt = any_exact ? exact_gnt : pathtgt_gnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q   <= '0;
         entries_q <= '0;
      end else if (cmd_valid) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (cmd_del) begin
               if (del_tgt[i]) valid_q[i] <= 1'b0;
            end else if (ins_tgt[i]) begin
               valid_q[i]   <= 1'b1;
               entries_q[i] <= cmd_entry;
            end
         end
      end
   end

   assign tbl_entries = entries_q;
   assign tbl_valid   = valid_q;

   // R8
   no_dup_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !narrow |-> $countones(exact_req) <= 1);

   // R8
   insert_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_del) |=> $countones(valid_q) >= $past($countones(valid_q)));

   // R10
   delete_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_del) |=> $countones(valid_q) <= $past($countones(valid_q)));

endmodule

// File: rtl/atm_circuit_matcher.sv
module atm_circuit_matcher #(
   parameter int DEPTH        = 8,
   parameter int ENTRY_W      = 64,
   parameter int KEY_W        = 32,
   parameter int OUT_W        = 32,
   parameter int VCI_W        = 16,
   parameter int VPI_W        = 12,
   parameter int VPI_NARROW_W = 8,
   parameter int PIPE_STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lookup_valid,
   input  logic [KEY_W-1:0]   lookup_key,
   input  logic               vpi_narrow,
   input  logic               cmd_valid,
   input  logic               cmd_del,
   input  logic [ENTRY_W-1:0] cmd_entry,
   output logic               result_valid,
   output logic               result_hit,
   output logic               result_path,
   output logic [OUT_W-1:0]   result_word
);

   import atm_match_pkg::*;

   localparam int VCI_LSB   = OUT_W;
   localparam int VPI_LSB   = OUT_W + VCI_W;
   localparam int FIELD_TOP = VPI_LSB + VPI_W;
   localparam int KEY_USED  = VCI_W + VPI_W;

   initial begin
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (FIELD_TOP <= ENTRY_W) else $error("entry fields exceed ENTRY_W");
      assert (KEY_USED <= KEY_W) else $error("key fields exceed KEY_W");
      assert (VPI_NARROW_W > 0 && VPI_NARROW_W <= VPI_W) else $error("bad narrow VPI width");
      assert (PIPE_STAGES == 1 || PIPE_STAGES == 2) else $error("PIPE_STAGES must be 1 or 2");
   end

   logic [DEPTH-1:0][ENTRY_W-1:0] tbl_entries;
   logic [DEPTH-1:0]              tbl_valid;

   atm_entry_table #(
      .DEPTH       (DEPTH),
      .ENTRY_W     (ENTRY_W),
      .OUT_W       (OUT_W),
      .VCI_W       (VCI_W),
      .VPI_W       (VPI_W),
      .VPI_NARROW_W(VPI_NARROW_W)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_del    (cmd_del),
      .cmd_entry  (cmd_entry),
      .narrow     (vpi_narrow),
      .tbl_entries(tbl_entries),
      .tbl_valid  (tbl_valid)
   );

   // ---------------- parallel compare ----------------
   logic [VPI_W-1:0] key_vpi;
   logic [VCI_W-1:0] key_vci;
   logic [DEPTH-1:0] l_vpi_eq, l_vci_eq, l_is_path;
   logic [DEPTH-1:0] chan_c, path_c;

   assign key_vci = lookup_key[0 +: VCI_W];
   assign key_vpi = lookup_key[VCI_W +: VPI_W];

   if (KEY_W > KEY_USED) begin : g_key_spare
      logic unused_key_hi;
      assign unused_key_hi = ^lookup_key[KEY_W-1:KEY_USED];
   end

   if (ENTRY_W > FIELD_TOP) begin : g_entry_spare
      logic [DEPTH-1:0] unused_entry_hi;
      for (genvar g = 0; g < DEPTH; g++) begin : g_bits
         assign unused_entry_hi[g] = ^tbl_entries[g][ENTRY_W-1:FIELD_TOP];
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_lookup_cmp
      atm_field_cmp #(
         .VCI_W       (VCI_W),
         .VPI_W       (VPI_W),
         .VPI_NARROW_W(VPI_NARROW_W)
      ) u_cmp (
         .entry_vpi (tbl_entries[g][VPI_LSB +: VPI_W]),
         .entry_vci (tbl_entries[g][VCI_LSB +: VCI_W]),
         .probe_vpi (key_vpi),
         .probe_vci (key_vci),
         .narrow    (vpi_narrow),
         .vpi_eq    (l_vpi_eq[g]),
         .vci_eq    (l_vci_eq[g]),
         .is_path   (l_is_path[g])
      );
      assign chan_c[g] = tbl_valid[g] & l_vpi_eq[g] & l_vci_eq[g] & ~l_is_path[g];
      assign path_c[g] = tbl_valid[g] & l_vpi_eq[g] & l_is_path[g];
   end

   // R1
   single_chan_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_valid && !vpi_narrow) |-> $countones(chan_c) <= 1);

   // ---------------- optional compare register ----------------
   logic [DEPTH-1:0] chan_s, path_s;
   logic             vld_s;

   if (PIPE_STAGES == 2) begin : g_cmp_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chan_s <= '0;
            path_s <= '0;
            vld_s  <= 1'b0;
         end else begin
            chan_s <= lookup_valid ? chan_c : '0;
            path_s <= lookup_valid ? path_c : '0;
            vld_s  <= lookup_valid;
         end
      end
   end else begin : g_cmp_flow
      assign chan_s = lookup_valid ? chan_c : '0;
      assign path_s = lookup_valid ? path_c : '0;
      assign vld_s  = lookup_valid;
   end

   // ---------------- select and output ----------------
   hit_kind_e        kind;
   logic [DEPTH-1:0] sel_req, sel_gnt;
   logic             sel_any;
   logic [OUT_W-1:0] sel_word;

   assign kind    = classify_hit(|chan_s, |path_s);
   assign sel_req = (kind == HIT_CHAN) ? chan_s : path_s;

   atm_first_pick #(.N(DEPTH)) u_pick_sel (.req(sel_req), .grant(sel_gnt), .any(sel_any));

   always_comb begin
      sel_word = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (sel_gnt[i]) sel_word = sel_word | tbl_entries[i][OUT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_valid <= 1'b0;
         result_hit   <= 1'b0;
         result_path  <= 1'b0;
         result_word  <= '0;
      end else begin
         result_valid <= vld_s;
         result_hit   <= vld_s && sel_any;
         result_path  <= vld_s && (kind == HIT_PATH);
         result_word  <= (vld_s && sel_any) ? sel_word : '0;
      end
   end

   // R2
   path_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_path |-> result_hit);

   // R3
   chan_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_path |-> $past(chan_s) == '0);

   // R4
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !result_hit |-> (result_word == '0 && !result_path));

   // R7
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $past(lookup_valid, PIPE_STAGES));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> (!result_hit && result_word == '0));

endmodule

// File: tb/test_atm_circuit_matcher.sv
module test_atm_circuit_matcher;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lookup_valid = 1'b0;
   logic [31:0] lookup_key = '0;
   logic        vpi_narrow = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_del = 1'b0;
   logic [63:0] cmd_entry = '0;
   logic        result_valid, result_hit, result_path;
   logic [31:0] result_word;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   atm_circuit_matcher i_atm_circuit_matcher (
      .clk(clk), .rst_n(rst_n),
      .lookup_valid(lookup_valid), .lookup_key(lookup_key), .vpi_narrow(vpi_narrow),
      .cmd_valid(cmd_valid), .cmd_del(cmd_del), .cmd_entry(cmd_entry),
      .result_valid(result_valid), .result_hit(result_hit),
      .result_path(result_path), .result_word(result_word)
   );

   typedef struct packed {
      logic        narrow;
      logic [31:0] key;
      logic        hit;
      logic        path;
      logic [31:0] word;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0123_0045, 1'b1, 1'b0, 32'hA000_0001},  // R1 R3
      '{1'b0, 32'h0123_0046, 1'b1, 1'b1, 32'hB000_0002},  // R2
      '{1'b0, 32'h02AB_0001, 1'b1, 1'b1, 32'hC000_0003},  // R2
      '{1'b0, 32'hA7FF_1234, 1'b1, 1'b0, 32'hD000_0004},  // R5
      '{1'b0, 32'h0124_0045, 1'b0, 1'b0, 32'h0000_0000},  // R4
      '{1'b0, 32'h07FF_1235, 1'b0, 1'b0, 32'h0000_0000},  // R4
      '{1'b0, 32'h02AB_FFFF, 1'b1, 1'b1, 32'hC000_0003},  // R2
      '{1'b1, 32'h55AB_0002, 1'b1, 1'b1, 32'hC000_0003},  // R6
      '{1'b1, 32'h7723_0045, 1'b1, 1'b0, 32'hA000_0001},  // R6
      '{1'b1, 32'h00FF_1234, 1'b1, 1'b0, 32'hD000_0004},  // R6
      '{1'b0, 32'h00FF_1234, 1'b0, 1'b0, 32'h0000_0000}   // R6
   };
   localparam string VTAG [NV] = '{"R1", "R2", "R2", "R5", "R4", "R4", "R2", "R6", "R6", "R6", "R6"};

   function automatic logic [63:0] mk_ent(input logic [3:0] top, input logic [11:0] vpi,
                                          input logic [15:0] vci, input logic [31:0] word);
      return {top, vpi, vci, word};
   endfunction

   function automatic logic [31:0] mk_key(input logic [11:0] vpi, input logic [15:0] vci);
      return {4'h0, vpi, vci};
   endfunction

   task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic command(input logic del, input logic [63:0] ent);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_del   = del;
      cmd_entry = ent;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // key sampled at edge k; result registered at edge k+2
   task automatic lookup(input string tag, input logic [31:0] key, input logic narrow,
                         input logic hit, input logic path, input logic [31:0] word);
      @(negedge clk);
      lookup_valid = 1'b1;
      lookup_key   = key;
      vpi_narrow   = narrow;
      @(negedge clk);
      lookup_valid = 1'b0;
      check("R7", "valid before latency", {63'd0, result_valid}, 64'd0);
      @(negedge clk);
      vpi_narrow = 1'b0;
      check("R7", "valid at latency", {63'd0, result_valid}, 64'd1);
      check(tag, "hit",  {63'd0, result_hit},  {63'd0, hit});
      check(tag, "path", {63'd0, result_path}, {63'd0, path});
      check(tag, "word", {32'd0, result_word}, {32'd0, word});
   endtask

   task automatic check_idle(input string tag);
      check(tag, "idle valid", {63'd0, result_valid}, 64'd0);
      check(tag, "idle hit",   {63'd0, result_hit},   64'd0);
      check(tag, "idle path",  {63'd0, result_path},  64'd0);
      check(tag, "idle word",  {32'd0, result_word},  64'd0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R13");
      rst_n = 1'b1;
      @(negedge clk);

      // base table: channel, path on same VPI, another path, channel with junk top bits
      command(1'b0, mk_ent(4'h0, 12'h123, 16'h0045, 32'hA000_0001));
      command(1'b0, mk_ent(4'h0, 12'h123, 16'hFFFF, 32'hB000_0002));
      command(1'b0, mk_ent(4'h0, 12'h2AB, 16'hFFFF, 32'hC000_0003));
      command(1'b0, mk_ent(4'hF, 12'h7FF, 16'h1234, 32'hD000_0004));

      for (int v = 0; v < NV; v++) begin
         lookup(VTAG[v], VECS[v].key, VECS[v].narrow, VECS[v].hit, VECS[v].path, VECS[v].word);
      end

      // R8: same key replaces
      command(1'b0, mk_ent(4'h0, 12'h123, 16'h0045, 32'hA111_1111));
      lookup("R8", mk_key(12'h123, 16'h0045), 1'b0, 1'b1, 1'b0, 32'hA111_1111);

      // R9: channel insert takes over path entry on VPI 2AB
      command(1'b0, mk_ent(4'h0, 12'h2AB, 16'h0777, 32'hE000_0005));
      lookup("R9", mk_key(12'h2AB, 16'h0777), 1'b0, 1'b1, 1'b0, 32'hE000_0005);
      lookup("R9", mk_key(12'h2AB, 16'h0001), 1'b0, 1'b0, 1'b0, 32'h0);

      // R11: absent channel delete removes the path on VPI 123, keeps its channel
      command(1'b1, mk_ent(4'h0, 12'h123, 16'h0999, 32'h0));
      lookup("R11", mk_key(12'h123, 16'h0046), 1'b0, 1'b0, 1'b0, 32'h0);
      lookup("R11", mk_key(12'h123, 16'h0045), 1'b0, 1'b1, 1'b0, 32'hA111_1111);

      // R10: exact delete
      command(1'b1, mk_ent(4'h0, 12'h7FF, 16'h1234, 32'h0));
      lookup("R10", mk_key(12'h7FF, 16'h1234), 1'b0, 1'b0, 1'b0, 32'h0);

      // fill the remaining six slots
      for (int i = 0; i < 6; i++) begin
         command(1'b0, mk_ent(4'h0, 12'h300 + 12'(i), 16'(i), 32'h5000_0000 + 32'(i)));
      end
      lookup("R12", mk_key(12'h305, 16'h0005), 1'b0, 1'b1, 1'b0, 32'h5000_0005);

      // R12: no target in a full table
      command(1'b0, mk_ent(4'h0, 12'h3FF, 16'h0010, 32'hF000_000F));
      lookup("R12", mk_key(12'h3FF, 16'h0010), 1'b0, 1'b0, 1'b0, 32'h0);

      // R8: replacement still works when full
      command(1'b0, mk_ent(4'h0, 12'h300, 16'h0000, 32'h6000_0000));
      lookup("R8", mk_key(12'h300, 16'h0000), 1'b0, 1'b1, 1'b0, 32'h6000_0000);

      // R13: reset clears the table
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R13");
      rst_n = 1'b1;
      lookup("R13", mk_key(12'h123, 16'h0045), 1'b0, 1'b0, 1'b0, 32'h0);
      lookup("R13", mk_key(12'h305, 16'h0005), 1'b0, 1'b0, 1'b0, 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule